// File: doc/BRIEF.md
# Programmable User-Mode Flash Transaction Engine

This block runs one serial flash transaction that software has put together in a set of configuration words. It is started by an execute request. On that request it takes a snapshot of the configuration, command, address and write-data inputs. It then moves through up to five phases, always in the same order. The first is an optional command byte. The second is zero to four address bytes. The third is a programmable run of write bytes. The fourth is a programmable number of dummy groups, which carry real data from the upper command bytes and are sent in chunks of 1, 2, 4 or 8 bits. The last is a programmable run of read bytes, which are stored into four read-data words.

Each transfer appears on a transfer port. The port has a valid/ready handshake, an 8-bit payload, a one-hot width code giving the number of payload bits that count, and a direction flag that marks read transfers. When software is not holding the chip select itself, the engine asserts the selected active-low chip-select line for the whole transaction and releases it at the end. When the transaction completes, the engine pulses a done signal, which stands for "ready status set", and drops its busy signal, which stands for "execute bit cleared". The register file that holds these words is outside this block.

Top module: `uma_xact_engine`

## Requirements
- R1: A command byte (command bits [7:0], width code 8) is sent first only when configuration bit 10 is 1.
- R2: Configuration bits [13:11] give N address bytes for N = 0 to 4, sent from address byte N-1 down to byte 0. Field values 5 to 7 send no address bytes.
- R3: Configuration bits [20:16] give the write byte count. Write byte i is byte (i mod 4) of data word i/4, where word w occupies wdata bits [32w+31:32w]. For i of 16 or more, word 3 is used.
- R4: Configuration bits [23:21] give the dummy group count. Group 0 sends command bits [15:8], group 1 sends bits [23:16], and every later group sends bits [31:24]. Each group is sent low bits first in chunks of 1 << cfg[7:6] bits, and the width code on the port equals that chunk width.
- R5: Configuration bits [28:24] give the read byte count. Read byte i is stored into rdata bits [8i+7:8i] when i < 16. Later bytes are clocked but dropped, and bytes that are not received keep their old value.
- R6: The phases run in the order command, address, write, dummy, read, and a phase with a zero count is skipped. A transaction with every count zero makes no transfer and still completes.
- R7: When the software chip-select bit is 0 at start, cs_n_o[dev] is low for the whole busy period. When that bit is 1, every chip-select line stays high. At most one line is ever low, and all lines are high while idle.
- R8: A device number at or above NCS asserts no chip-select line and sets dev_err_o. dev_err_o holds until the next accepted start.
- R9: busy_o rises on the clock edge that accepts the execute request. Completion produces exactly one done_o pulse in the same cycle that busy_o falls.
- R10: While xfer_valid_o is high and xfer_ready_i is low, the payload, width code and direction hold steady.
- R11: After reset, busy_o, done_o, dev_err_o and xfer_valid_o are 0, every chip-select line is high and rdata_o is zero.
- R12: An execute request, and any change to the configuration inputs, while busy has no effect on the running transaction and starts no new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_i | input | 1 | Execute request, taken when idle |
| cfg_i | input | 32 | Transaction configuration word |
| cmd_i | input | 32 | Command byte and dummy source bytes |
| addr_i | input | 32 | Flash address |
| wdata_i | input | NWORDS*32 | Write data words, word 0 lowest |
| sw_cs_i | input | 1 | 1 = software holds the chip select, so the engine leaves it alone |
| dev_i | input | DEVW | Chip-select number |
| xfer_valid_o | output | 1 | Transfer offered |
| xfer_ready_i | input | 1 | Transfer taken in this cycle |
| xfer_data_o | output | 8 | Transfer payload, low bits used |
| xfer_bits_o | output | 4 | Payload width code: 1, 2, 4 or 8 |
| xfer_rd_o | output | 1 | Read transfer |
| xfer_rdata_i | input | 8 | Byte returned on a read transfer |
| cs_n_o | output | NCS | Active-low chip selects |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dev_err_o | output | 1 | Device number out of range |
| rdata_o | output | NWORDS*32 | Read data words |

## Verification
The assertions take for granted that xfer_ready_i and xfer_rdata_i are known and change only between clock edges. They also rely on the execute request being the only way into a transaction, so busy can only rise after a request. The bench drives every input on the falling edge. It changes xfer_rdata_i only in the half cycle in which it offers a read, so the returned byte is stable at the accepting edge. While the engine is busy, the bench scrambles the configuration inputs and repeats the execute request. This checks that the snapshot decouples the running transaction from the live inputs.

// File: rtl/uma_pkg.sv
package uma_pkg;

   localparam int CW = 7;

   localparam int F_CMDSZ   = 10;
   localparam int F_ADDR_LO = 11;
   localparam int F_WR_LO   = 16;
   localparam int F_DUM_LO  = 21;
   localparam int F_RD_LO   = 24;
   localparam int F_DBW_LO  = 6;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CMD  = 3'd1,
      PH_ADDR = 3'd2,
      PH_WR   = 3'd3,
      PH_DUM  = 3'd4,
      PH_RD   = 3'd5,
      PH_FIN  = 3'd6
   } phase_t;

   typedef struct packed {
      logic [CW-1:0] n_cmd;
      logic [CW-1:0] n_addr;
      logic [CW-1:0] n_wr;
      logic [CW-1:0] n_dum;
      logic [CW-1:0] n_rd;
   } counts_t;

   function automatic logic [CW-1:0] count_of(phase_t p, counts_t c);
      case (p)
         PH_CMD:  return c.n_cmd;
         PH_ADDR: return c.n_addr;
         PH_WR:   return c.n_wr;
         PH_DUM:  return c.n_dum;
         PH_RD:   return c.n_rd;
         default: return '0;
      endcase
   endfunction

   function automatic phase_t next_phase(phase_t p, counts_t c);
      phase_t r;
      r = PH_FIN;
      for (int k = 5; k >= 1; k--) begin
         if (k > int'(p) && count_of(phase_t'(k), c) != '0) r = phase_t'(k);
      end
      return r;
   endfunction

endpackage

// File: rtl/uma_seq.sv
module uma_seq
   import uma_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          step_i,
   input  counts_t       cnt_i,
   output phase_t        phase_o,
   output logic [CW-1:0] idx_o,
   output logic          done_o
);

   logic [CW-1:0] last_idx;

   always_comb last_idx = count_of(phase_o, cnt_i) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_o <= PH_IDLE;
         idx_o   <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         case (phase_o)
            PH_IDLE: begin
               if (start_i) begin
                  phase_o <= next_phase(PH_IDLE, cnt_i);
                  idx_o   <= '0;
               end
            end
            PH_FIN: begin
               phase_o <= PH_IDLE;
               done_o  <= 1'b1;
            end
            default: begin
               if (step_i) begin
                  if (idx_o == last_idx) begin
                     phase_o <= next_phase(phase_o, cnt_i);
                     idx_o   <= '0;
                  end else begin
                     idx_o <= idx_o + 1'b1;
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/uma_payload.sv
module uma_payload
   import uma_pkg::*;
#(
   parameter int NWORDS = 4
) (
   input  phase_t               phase_i,
   input  logic [CW-1:0]        idx_i,
   input  logic [31:0]          cfg_i,
   input  logic [31:0]          cmd_i,
   input  logic [31:0]          addr_i,
   input  logic [NWORDS*32-1:0] wdata_i,
   output logic [7:0]           data_o,
   output logic [3:0]           bits_o,
   output logic                 rd_o
);

   localparam int NB = NWORDS * 4;
   localparam int IW = $clog2(NB);

   logic [2:0]    an;
   logic [1:0]    asel;
   logic [IW-1:0] wsel;
   logic [1:0]    sh;
   logic [1:0]    lg;
   logic [CW-1:0] grp;
   logic [2:0]    chunk;
   logic [2:0]    boff;
   logic [7:0]    src;
   logic [7:0]    mask;

   always_comb begin
      an    = cfg_i[F_ADDR_LO +: 3];
      asel  = 2'(an - 3'd1 - idx_i[2:0]);
      if (idx_i >= CW'(NB)) wsel = IW'(NB - 4) | IW'(idx_i[1:0]);
      else                  wsel = idx_i[IW-1:0];
      sh    = cfg_i[F_DBW_LO +: 2];
      lg    = 2'd3 - sh;
      grp   = idx_i >> lg;
      chunk = 3'(idx_i & ((CW'(1) << lg) - CW'(1)));
      boff  = 3'(chunk << sh);
      case (grp)
         CW'(0):  src = cmd_i[15:8];
         CW'(1):  src = cmd_i[23:16];
         default: src = cmd_i[31:24];
      endcase
      case (sh)
         2'd0:    mask = 8'h01;
         2'd1:    mask = 8'h03;
         2'd2:    mask = 8'h0F;
         default: mask = 8'hFF;
      endcase
   end

   always_comb begin
      data_o = '0;
      bits_o = 4'd8;
      rd_o   = 1'b0;
      case (phase_i)
         PH_CMD:  data_o = cmd_i[7:0];
         PH_ADDR: data_o = addr_i[{asel, 3'b000} +: 8];
         PH_WR:   data_o = wdata_i[{wsel, 3'b000} +: 8];
         PH_DUM: begin
            bits_o = 4'd1 << sh;
            data_o = (src >> boff) & mask;
         end
         PH_RD:   rd_o = 1'b1;
         default: data_o = '0;
      endcase
   end

endmodule

// File: rtl/uma_rdstore.sv
module uma_rdstore
   import uma_pkg::*;
#(
   parameter int NWORDS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we_i,
   input  logic [CW-1:0]        idx_i,
   input  logic [7:0]           byte_i,
   output logic [NWORDS*32-1:0] rdata_o
);

   localparam int NB = NWORDS * 4;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         rdata_o[b*8 +: 8] <= '0;
         else if (we_i && idx_i == CW'(b))   rdata_o[b*8 +: 8] <= byte_i;
      end
   end

endmodule

// File: rtl/uma_xact_engine.sv
module uma_xact_engine
   import uma_pkg::*;
#(
   parameter int NCS    = 3,
   parameter int DEVW   = 2,
   parameter int NWORDS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 exec_i,
   input  logic [31:0]          cfg_i,
   input  logic [31:0]          cmd_i,
   input  logic [31:0]          addr_i,
   input  logic [NWORDS*32-1:0] wdata_i,
   input  logic                 sw_cs_i,
   input  logic [DEVW-1:0]      dev_i,
   output logic                 xfer_valid_o,
   input  logic                 xfer_ready_i,
   output logic [7:0]           xfer_data_o,
   output logic [3:0]           xfer_bits_o,
   output logic                 xfer_rd_o,
   input  logic [7:0]           xfer_rdata_i,
   output logic [NCS-1:0]       cs_n_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 dev_err_o,
   output logic [NWORDS*32-1:0] rdata_o
);

   localparam int NB = NWORDS * 4;

   if (NCS < 1 || NCS > (1 << DEVW)) begin : g_bad_ncs
      $error("NCS must lie in 1 .. 2**DEVW");
   end
   if (NWORDS < 1 || NB > 64) begin : g_bad_words
      $error("NWORDS out of range");
   end

   phase_t               phase;
   logic [CW-1:0]        idx;
   logic                 start_ok;
   logic                 step;
   logic [31:0]          cfg_q, cmd_q, addr_q, cfg_eff;
   logic [NWORDS*32-1:0] wdata_q;
   logic                 own_q;
   logic [DEVW-1:0]      dev_q;
   logic [2:0]           an;
   counts_t              cnt;

   assign busy_o       = (phase != PH_IDLE);
   assign xfer_valid_o = busy_o && (phase != PH_FIN);
   assign start_ok     = exec_i && !busy_o;
   assign step         = xfer_valid_o && xfer_ready_i;
   assign cfg_eff      = busy_o ? cfg_q : cfg_i;

   always_comb begin
      an         = cfg_eff[F_ADDR_LO +: 3];
      cnt.n_cmd  = CW'(cfg_eff[F_CMDSZ]);
      cnt.n_addr = (an <= 3'd4) ? CW'(an) : '0;
      cnt.n_wr   = CW'(cfg_eff[F_WR_LO +: 5]);
      cnt.n_dum  = CW'(cfg_eff[F_DUM_LO +: 3]) << (2'd3 - cfg_eff[F_DBW_LO +: 2]);
      cnt.n_rd   = CW'(cfg_eff[F_RD_LO +: 5]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         cmd_q     <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
         own_q     <= 1'b0;
         dev_q     <= '0;
         dev_err_o <= 1'b0;
      end else if (start_ok) begin
         cfg_q     <= cfg_i;
         cmd_q     <= cmd_i;
         addr_q    <= addr_i;
         wdata_q   <= wdata_i;
         own_q     <= !sw_cs_i;
         dev_q     <= dev_i;
         dev_err_o <= !sw_cs_i && (int'(dev_i) >= NCS);
      end
   end

   for (genvar c = 0; c < NCS; c++) begin : g_cs
      assign cs_n_o[c] = !(busy_o && own_q && dev_q == DEVW'(c));
   end

   uma_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_ok),
      .step_i  (step),
      .cnt_i   (cnt),
      .phase_o (phase),
      .idx_o   (idx),
      .done_o  (done_o)
   );

   uma_payload #(.NWORDS(NWORDS)) u_pay (
      .phase_i (phase),
      .idx_i   (idx),
      .cfg_i   (cfg_q),
      .cmd_i   (cmd_q),
      .addr_i  (addr_q),
      .wdata_i (wdata_q),
      .data_o  (xfer_data_o),
      .bits_o  (xfer_bits_o),
      .rd_o    (xfer_rd_o)
   );

   uma_rdstore #(.NWORDS(NWORDS)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (step && phase == PH_RD && idx < CW'(NB)),
      .idx_i   (idx),
      .byte_i  (xfer_rdata_i),
      .rdata_o (rdata_o)
   );

endmodule

// File: rtl/uma_xact_chk.sv
module uma_xact_chk #(
   parameter int NCS = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           exec_i,
   input logic           xfer_valid_o,
   input logic           xfer_ready_i,
   input logic [7:0]     xfer_data_o,
   input logic [3:0]     xfer_bits_o,
   input logic           xfer_rd_o,
   input logic [NCS-1:0] cs_n_o,
   input logic           busy_o,
   input logic           done_o,
   input logic           dev_err_o
);

   a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_data_o)
                                        && $stable(xfer_bits_o) && $stable(xfer_rd_o));

   a_r7_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n_o) <= 1);

   a_r7_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> &cs_n_o);

   a_r8_err_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
      dev_err_o |-> &cs_n_o);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r9_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   a_r6_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid_o |-> busy_o);

   a_r4_width_code: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid_o |-> $countones(xfer_bits_o) == 1);

   a_r12_start_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(exec_i));

endmodule

bind uma_xact_engine uma_xact_chk #(.NCS(NCS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .exec_i       (exec_i),
   .xfer_valid_o (xfer_valid_o),
   .xfer_ready_i (xfer_ready_i),
   .xfer_data_o  (xfer_data_o),
   .xfer_bits_o  (xfer_bits_o),
   .xfer_rd_o    (xfer_rd_o),
   .cs_n_o       (cs_n_o),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .dev_err_o    (dev_err_o)
);

// File: tb/sim_uma_xact_engine.sv
`timescale 1ns/1ps
module sim_uma_xact_engine;

   localparam int NCS = 3;
   localparam int DEVW = 2;
   localparam int NWORDS = 4;

   // {sw_cs, dev, stall, cfg, cmd, addr}
   localparam logic [99:0] VEC [0:6] = '{
      {1'b0, 2'd0, 1'b0, 32'h04001C00, 32'h0B0A0903, 32'h00123456},
      {1'b0, 2'd1, 1'b1, 32'h00052000, 32'h00000000, 32'hA1B2C3D4},
      {1'b0, 2'd2, 1'b0, 32'h00600480, 32'h5AC3E702, 32'h00000000},
      {1'b1, 2'd0, 1'b1, 32'h14403800, 32'h00C3A500, 32'h76543210},
      {1'b0, 2'd3, 1'b0, 32'h00340CC0, 32'h11223344, 32'h000000EE},
      {1'b0, 2'd0, 1'b0, 32'h00000000, 32'h00000000, 32'h00000000},
      {1'b0, 2'd1, 1'b1, 32'h03800040, 32'h9C6B2D00, 32'h00000000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic exec = 1'b0;
   logic [31:0] cfg = '0, cmd = '0, addr = '0;
   logic [NWORDS*32-1:0] wdata = '0;
   logic sw_cs = 1'b0;
   logic [DEVW-1:0] dev = '0;
   logic ready = 1'b1;
   logic [7:0] rdata_in = '0;
   logic xfer_valid, xfer_rd, busy, done, dev_err;
   logic [7:0] xfer_data;
   logic [3:0] xfer_bits;
   logic [NCS-1:0] cs_n;
   logic [NWORDS*32-1:0] rdata;

   always #10 clk = ~clk;

   uma_xact_engine #(.NCS(NCS), .DEVW(DEVW), .NWORDS(NWORDS)) u0 (
      .clk(clk), .rst_n(rst_n), .exec_i(exec), .cfg_i(cfg), .cmd_i(cmd),
      .addr_i(addr), .wdata_i(wdata), .sw_cs_i(sw_cs), .dev_i(dev),
      .xfer_valid_o(xfer_valid), .xfer_ready_i(ready), .xfer_data_o(xfer_data),
      .xfer_bits_o(xfer_bits), .xfer_rd_o(xfer_rd), .xfer_rdata_i(rdata_in),
      .cs_n_o(cs_n), .busy_o(busy), .done_o(done), .dev_err_o(dev_err),
      .rdata_o(rdata)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int nact = 0, nexp = 0, rdn = 0, cs_bad = 0, done_cnt = 0;
   bit stall_en = 1'b0;
   logic [NCS-1:0] exp_cs = '1;
   logic [7:0] act_d [0:255];
   logic [3:0] act_b [0:255];
   logic       act_r [0:255];
   logic [7:0] exp_d [0:255];
   logic [3:0] exp_b [0:255];
   logic       exp_r [0:255];
   int         exp_p [0:255];
   logic [NWORDS*32-1:0] exp_rdata = '0;
   string ptag [1:5] = '{"R1", "R2", "R3", "R4", "R5"};

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] d, input logic [3:0] b, input logic r, input int p);
      exp_d[nexp] = d; exp_b[nexp] = b; exp_r[nexp] = r; exp_p[nexp] = p;
      nexp++;
   endtask

   // Expected transfer list, built from the requirement text
   task automatic build(input logic [31:0] c, input logic [31:0] m, input logic [31:0] a);
      int na, bp;
      logic [7:0] s;
      nexp = 0;
      if (c[10]) push(m[7:0], 4'd8, 1'b0, 1);                      // R1
      na = int'(c[13:11]);
      if (na <= 4) for (int k = na - 1; k >= 0; k--)
         push(a[k*8 +: 8], 4'd8, 1'b0, 2);                         // R2
      for (int i = 0; i < int'(c[20:16]); i++) begin               // R3
         int w;
         w = (i < 16) ? i / 4 : 3;
         push(wdata[(w*4 + i%4)*8 +: 8], 4'd8, 1'b0, 3);
      end
      bp = 1 << c[7:6];
      for (int g = 0; g < int'(c[23:21]); g++) begin               // R4
         s = (g == 0) ? m[15:8] : (g == 1) ? m[23:16] : m[31:24];
         for (int j = 0; j < 8; j += bp)
            push(8'((s >> j) & ((1 << bp) - 1)), 4'(bp), 1'b0, 4);
      end
      for (int i = 0; i < int'(c[28:24]); i++) begin               // R5
         push(8'h00, 4'd8, 1'b1, 5);
         if (i < 16) exp_rdata[i*8 +: 8] = 8'h30 + 8'(i);
      end
   endtask

   // Port monitor and responder, all on the falling edge
   always @(negedge clk) begin
      cyc++;
      ready = stall_en ? (cyc % 3 != 0) : 1'b1;
      if (xfer_valid && ready) begin
         if (nact < 256) begin
            act_d[nact] = xfer_data; act_b[nact] = xfer_bits; act_r[nact] = xfer_rd;
         end
         nact++;
         if (xfer_rd) begin
            rdata_in = 8'h30 + 8'(rdn);
            rdn++;
         end
      end
      if (busy ? (cs_n !== exp_cs) : (cs_n !== '1)) cs_bad++;
      if (done) done_cnt++;
   end

   task automatic run(input int v);
      logic s; logic [1:0] d; logic st; logic [31:0] c, m, a;
      int guard, bad, seen;
      logic [NWORDS*32-1:0] pre_rdata;
      {s, d, st, c, m, a} = VEC[v];
      pre_rdata = exp_rdata;
      build(c, m, a);
      exp_cs = '1;
      if (!s && int'(d) < NCS) exp_cs[d] = 1'b0;
      nact = 0; rdn = 0; cs_bad = 0; done_cnt = 0; stall_en = st;
      cfg = c; cmd = m; addr = a; sw_cs = s; dev = d; exec = 1'b1;
      @(negedge clk);
      #1;
      chk(busy === 1'b1, "R9", $sformatf("busy after start v%0d", v), 128'(busy), 128'd1);
      // R12: scramble inputs and repeat the request while busy
      cfg = ~c; cmd = ~m; addr = ~a; sw_cs = ~s; dev = ~d;
      @(negedge clk);
      #1;
      exec = 1'b0;
      guard = 0;
      while (busy && guard < 3000) begin
         @(negedge clk); #1; guard++;
      end
      seen = nact;
      repeat (4) @(negedge clk);
      #1;
      chk(busy === 1'b0 && nact == seen, "R12", $sformatf("no second transaction v%0d", v),
          128'(nact), 128'(seen));
      chk(done_cnt == 1, "R9", $sformatf("done pulses v%0d", v), 128'(done_cnt), 128'd1);
      chk(nact == nexp, "R6", $sformatf("transfer count v%0d", v), 128'(nact), 128'(nexp));
      for (int p = 1; p <= 5; p++) begin
         bad = 0;
         for (int i = 0; i < nexp && i < nact && i < 256; i++)
            if (exp_p[i] == p && (act_d[i] !== exp_d[i] || act_b[i] !== exp_b[i]
                                  || act_r[i] !== exp_r[i])) bad++;
         chk(bad == 0, ptag[p], $sformatf("phase %0d payload mismatches v%0d", p, v),
             128'(bad), 128'd0);
      end
      chk(rdata === exp_rdata, "R5", $sformatf("read words v%0d", v), rdata, exp_rdata);
      if (int'(c[28:24]) == 0)
         chk(rdata === pre_rdata, "R5", $sformatf("read words untouched v%0d", v), rdata, pre_rdata);
      chk(cs_bad == 0, "R7", $sformatf("chip select cycles wrong v%0d", v), 128'(cs_bad), 128'd0);
      chk(dev_err === (!s && int'(d) >= NCS), "R8", $sformatf("dev_err v%0d", v),
          128'(dev_err), 128'(!s && int'(d) >= NCS));
   endtask

   initial begin
      #(20ns * 150000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NWORDS * 4; i++) wdata[i*8 +: 8] = 8'h80 + 8'(i);
      repeat (3) @(negedge clk);
      #1;
      // R11 reset state
      chk(busy === 1'b0 && done === 1'b0, "R11", "busy/done in reset", {busy, done}, 128'd0);
      chk(cs_n === '1, "R11", "cs_n in reset", 128'(cs_n), 128'(3'b111));
      chk(rdata === '0 && xfer_valid === 1'b0 && dev_err === 1'b0, "R11",
          "rdata/valid/dev_err in reset", rdata, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(busy === 1'b0 && xfer_valid === 1'b0, "R11", "idle after reset release",
          {xfer_valid, busy}, 128'd0);
      for (int v = 0; v < 7; v++) run(v);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule